// File: doc/BRIEF.md
# CPU halt and wake controller

This block sits between a small 8-bit processor core and its external bus. When the core decodes its halt instruction it raises a halt request. The controller then enters a low-power halt state. In that state it tells the core to stop advancing the program counter and to stay idle, and it parks the external bus. The address lines keep the last address the core issued. The data lines are driven low, and every active-low bus strobe is held high. The clocks keep running during halt, so only the controller's own state decides when the core resumes.

Five sources can end the halt state. Two are interrupt-type and act on a clock edge: a nonmaskable interrupt, and a maskable interrupt when global interrupts are enabled. Three are reset-type and act at once, without waiting for a clock edge: the external reset pin driven low, a reset command from the debug port, and a watchdog timeout. A watchdog timeout counts as interrupt-type or reset-type according to how the watchdog is configured. The `halted` flag shows whether the core is halted. The `pc_freeze` output holds the core for the whole time the halt state register is set.

Top module: `cpu_halt_ctrl`

## Requirements
- R1: While `ext_reset_n` is low, the controller is in its run state, with `halted`=0 and `pc_freeze`=0. A halt request is ignored during this time.
- R2: In the run state, a `halt_req` that is high at a rising clock edge, with no qualified interrupt wake in that cycle, sets `pc_freeze` and `halted` from that edge on.
- R3: `pc_freeze` stays 1 in every cycle of the halt state, including the cycle in which an interrupt wake is sampled. It falls at the next rising edge.
- R4: Throughout the halt state, `ext_addr` holds the value `cpu_addr` had at the entry edge, whatever `cpu_addr` does afterwards.
- R5: In any cycle where `halt_req` is high or the halt state is held, the bus is parked. Parked means `ext_data`=0, `ext_data_oe`=1, and all of these are 1: `ext_mem_req_n`, every bit of `ext_chip_sel_n`, `ext_fetch_n`, `ext_grant_n`, `ext_io_req_n`, `ext_read_n` and `ext_write_n`.
- R6: When the bus is not parked, every `ext_*` output equals its `cpu_*` counterpart in the same cycle.
- R7: A high `nmi_req` always wakes the core. `halted` falls in the same cycle and the run state is entered at the next edge.
- R8: `irq_req` wakes the core only while `irq_gie`=1. With `irq_gie`=0, the halt state and the held address are unaffected.
- R9: `wdt_mode` sets the role of `wdt_timeout`. 2'b01 makes it an interrupt-type wake. 2'b10 makes it a reset-type wake. 2'b00 and 2'b11 leave it with no effect on the halt state.
- R10: A reset-type wake clears `halted` and `pc_freeze` without waiting for a clock edge. The reset-type wakes are `ext_reset_n` low, `dbg_reset` high, or `wdt_timeout` high with `wdt_mode`=2'b10.
- R11: A `halt_req` sampled in the same cycle as a qualified interrupt wake does not enter the halt state.
- R12: A `halt_req` received while already halted has no effect. The state and the held address remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, running during halt |
| ext_reset_n | input | 1 | External reset pin, active low, asynchronous |
| dbg_reset | input | 1 | Reset command from the debug port |
| halt_req | input | 1 | Halt instruction decoded by the core |
| nmi_req | input | 1 | Nonmaskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_gie | input | 1 | Global interrupt enable |
| wdt_timeout | input | 1 | Watchdog timeout event |
| wdt_mode | input | 2 | Watchdog timeout action: 00 none, 01 NMI, 10 reset, 11 none |
| cpu_addr | input | ADDR_W | Address from the core |
| cpu_data | input | DATA_W | Write data from the core |
| cpu_data_oe | input | 1 | Data-bus drive enable from the core |
| cpu_mem_req_n | input | 1 | Memory request strobe from the core |
| cpu_chip_sel_n | input | NUM_CS | Chip selects from the core |
| cpu_fetch_n | input | 1 | Instruction fetch strobe from the core |
| cpu_grant_n | input | 1 | Bus grant acknowledge from the core |
| cpu_io_req_n | input | 1 | I/O request strobe from the core |
| cpu_read_n | input | 1 | Read strobe from the core |
| cpu_write_n | input | 1 | Write strobe from the core |
| ext_addr | output | ADDR_W | External address bus |
| ext_data | output | DATA_W | External data bus |
| ext_data_oe | output | 1 | External data-bus drive enable |
| ext_mem_req_n | output | 1 | External memory request strobe |
| ext_chip_sel_n | output | NUM_CS | External chip selects |
| ext_fetch_n | output | 1 | External instruction fetch strobe |
| ext_grant_n | output | 1 | External bus grant acknowledge |
| ext_io_req_n | output | 1 | External I/O request strobe |
| ext_read_n | output | 1 | External read strobe |
| ext_write_n | output | 1 | External write strobe |
| pc_freeze | output | 1 | Holds the core's program counter and keeps the core idle |
| halted | output | 1 | Halt status flag |

## Verification
The embedded properties check several behaviours on every clocked cycle: halt entry, the one-edge exit after an interrupt wake, refusal of entry when a wake coincides with the request, the masking of interrupts by the global enable, the stable address during halt, and the parked or pass-through bus levels. Some behaviours can only be shown by the bench's scenarios. One is that a reset-type source clears the flags between clock edges. Others are that a watchdog timeout in modes 00 and 11 does nothing, and that the held address equals the one captured at entry rather than just any stable value. These are all compared against a behavioural model on every cycle.

// File: rtl/halt_pkg.sv
package halt_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } hstate_e;

  // watchdog timeout action encodings
  localparam logic [1:0] WDM_NONE = 2'b00;
  localparam logic [1:0] WDM_NMI  = 2'b01;
  localparam logic [1:0] WDM_RST  = 2'b10;
  localparam logic [1:0] WDM_RSV  = 2'b11;

  // wake sources handled on a clock edge
  function automatic logic wake_intr(input logic nmi, input logic irq,
                                     input logic gie, input logic wdt_to,
                                     input logic [1:0] mode);
    return nmi | (irq & gie) | (wdt_to & (mode == WDM_NMI));
  endfunction

  // wake sources that reset the controller immediately
  function automatic logic wake_reset(input logic pin_n, input logic dbg,
                                      input logic wdt_to, input logic [1:0] mode);
    return ~pin_n | dbg | (wdt_to & (mode == WDM_RST));
  endfunction

endpackage

// File: rtl/halt_wake_qual.sv
module halt_wake_qual
  import halt_pkg::*;
(
  input  logic       clk,
  input  logic       ext_reset_n,
  input  logic       dbg_reset,
  input  logic       nmi_req,
  input  logic       irq_req,
  input  logic       irq_gie,
  input  logic       wdt_timeout,
  input  logic [1:0] wdt_mode,
  output logic       int_wake,
  output logic       sys_rst_n
);

  logic rst_wake;

  assign int_wake  = wake_intr(nmi_req, irq_req, irq_gie, wdt_timeout, wdt_mode);
  assign rst_wake  = wake_reset(ext_reset_n, dbg_reset, wdt_timeout, wdt_mode);
  assign sys_rst_n = ~rst_wake;

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!irq_gie && !nmi_req && !(wdt_timeout && wdt_mode == WDM_NMI)) |-> !int_wake);

  // R7
  nmi_always_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    nmi_req |-> int_wake);

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
(
  input  logic clk,
  input  logic sys_rst_n,
  input  logic halt_req,
  input  logic int_wake,
  output logic pc_freeze,
  output logic halted,
  output logic enter_evt,
  output logic exit_evt
);

  hstate_e state_q, state_d;

  assign enter_evt = (state_q == ST_RUN) && halt_req && !int_wake;
  assign exit_evt  = (state_q == ST_HALT) && int_wake;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (enter_evt) state_d = ST_HALT;
      ST_HALT: if (exit_evt)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) state_q <= ST_RUN;
    else            state_q <= state_d;
  end

  assign pc_freeze = (state_q == ST_HALT);
  assign halted    = pc_freeze && !int_wake;

  // R2
  enter_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    enter_evt |=> (pc_freeze && halted) || int_wake);

  // R3
  exit_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    exit_evt |=> !pc_freeze);

  // R7
  same_cycle_drop_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pc_freeze && int_wake) |-> !halted);

  // R11
  no_enter_on_wake_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!pc_freeze && int_wake) |=> !pc_freeze);

  // R12
  stay_halted_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pc_freeze && !int_wake) |=> pc_freeze);

endmodule

// File: rtl/halt_bus_park.sv
module halt_bus_park #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int STB_W  = 10
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              park_hold,
  input  logic              park_pre,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_data_oe,
  input  logic [STB_W-1:0]  cpu_stb_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_data,
  output logic              ext_data_oe,
  output logic [STB_W-1:0]  ext_stb_n
);

  logic              park;
  logic [ADDR_W-1:0] addr_q;

  assign park = park_hold | park_pre;

  // address register follows the core while running, freezes in halt
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)     addr_q <= '0;
    else if (!park_hold) addr_q <= cpu_addr;
  end

  assign ext_addr    = park_hold ? addr_q : cpu_addr;
  assign ext_data_oe = park | cpu_data_oe;

  for (genvar d = 0; d < DATA_W; d++) begin : g_data
    assign ext_data[d] = cpu_data[d] & ~park;
  end

  for (genvar s = 0; s < STB_W; s++) begin : g_stb
    assign ext_stb_n[s] = cpu_stb_n[s] | park;
  end

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (park_hold && $past(park_hold)) |-> $stable(ext_addr));

  // R5
  park_levels_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    park |-> (ext_data == '0) && ext_data_oe && (&ext_stb_n));

  // R6
  pass_through_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !park |-> (ext_data == cpu_data) && (ext_stb_n == cpu_stb_n) &&
              (ext_addr == cpu_addr) && (ext_data_oe == cpu_data_oe));

endmodule

// File: rtl/cpu_halt_ctrl.sv
module cpu_halt_ctrl
  import halt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              ext_reset_n,
  input  logic              dbg_reset,
  input  logic              halt_req,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              irq_gie,
  input  logic              wdt_timeout,
  input  logic [1:0]        wdt_mode,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_data_oe,
  input  logic              cpu_mem_req_n,
  input  logic [NUM_CS-1:0] cpu_chip_sel_n,
  input  logic              cpu_fetch_n,
  input  logic              cpu_grant_n,
  input  logic              cpu_io_req_n,
  input  logic              cpu_read_n,
  input  logic              cpu_write_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_data,
  output logic              ext_data_oe,
  output logic              ext_mem_req_n,
  output logic [NUM_CS-1:0] ext_chip_sel_n,
  output logic              ext_fetch_n,
  output logic              ext_grant_n,
  output logic              ext_io_req_n,
  output logic              ext_read_n,
  output logic              ext_write_n,
  output logic              pc_freeze,
  output logic              halted
);

  localparam int STB_W = NUM_CS + 6;

  logic             int_wake;
  logic             sys_rst_n;
  logic             enter_evt;
  logic             exit_evt;
  logic [STB_W-1:0] cpu_stb_n;
  logic [STB_W-1:0] ext_stb_n;

  assign cpu_stb_n = {cpu_mem_req_n, cpu_chip_sel_n, cpu_fetch_n,
                      cpu_grant_n, cpu_io_req_n, cpu_read_n, cpu_write_n};
  assign {ext_mem_req_n, ext_chip_sel_n, ext_fetch_n,
          ext_grant_n, ext_io_req_n, ext_read_n, ext_write_n} = ext_stb_n;

  halt_wake_qual u_qual (
    .clk         (clk),
    .ext_reset_n (ext_reset_n),
    .dbg_reset   (dbg_reset),
    .nmi_req     (nmi_req),
    .irq_req     (irq_req),
    .irq_gie     (irq_gie),
    .wdt_timeout (wdt_timeout),
    .wdt_mode    (wdt_mode),
    .int_wake    (int_wake),
    .sys_rst_n   (sys_rst_n)
  );

  halt_fsm u_fsm (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .halt_req  (halt_req),
    .int_wake  (int_wake),
    .pc_freeze (pc_freeze),
    .halted    (halted),
    .enter_evt (enter_evt),
    .exit_evt  (exit_evt)
  );

  halt_bus_park #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STB_W  (STB_W)
  ) u_park (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .park_hold   (pc_freeze),
    .park_pre    (halt_req),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_data_oe (cpu_data_oe),
    .cpu_stb_n   (cpu_stb_n),
    .ext_addr    (ext_addr),
    .ext_data    (ext_data),
    .ext_data_oe (ext_data_oe),
    .ext_stb_n   (ext_stb_n)
  );

  // R9
  wdt_reserved_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (pc_freeze && wdt_timeout && (wdt_mode == WDM_NONE || wdt_mode == WDM_RSV) &&
     !nmi_req && !(irq_req && irq_gie)) |=> pc_freeze);

  // R3
  exit_ordering_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    exit_evt |-> pc_freeze && !enter_evt);

endmodule

// File: tb/test_cpu_halt_ctrl.sv
module test_cpu_halt_ctrl;
  localparam int AW = 24, DW = 8, NCS = 4, SW = NCS + 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          ext_reset_n = 1'b0, dbg_reset = 1'b0, halt_req = 1'b0;
  logic          nmi_req = 1'b0, irq_req = 1'b0, irq_gie = 1'b0, wdt_timeout = 1'b0;
  logic [1:0]    wdt_mode = 2'b00;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_data = '0;
  logic          cpu_data_oe = 1'b0;
  logic [SW-1:0] cst = '1;

  // staged values, copied onto the inputs at a falling edge
  logic       s_rst_n = 1'b0, s_dbg = 1'b0, s_halt = 1'b0, s_nmi = 1'b0;
  logic       s_irq = 1'b0, s_gie = 1'b0, s_wdt = 1'b0;
  logic [1:0] s_mode = 2'b00;

  logic [AW-1:0]  ext_addr;
  logic [DW-1:0]  ext_data;
  logic           ext_data_oe, ext_mem_req_n, ext_fetch_n, ext_grant_n;
  logic           ext_io_req_n, ext_read_n, ext_write_n, pc_freeze, halted;
  logic [NCS-1:0] ext_chip_sel_n;

  cpu_halt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_CS(NCS)) i_cpu_halt_ctrl (
    .clk(clk), .ext_reset_n(ext_reset_n), .dbg_reset(dbg_reset), .halt_req(halt_req),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_gie(irq_gie), .wdt_timeout(wdt_timeout),
    .wdt_mode(wdt_mode), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_data_oe(cpu_data_oe),
    .cpu_mem_req_n(cst[SW-1]), .cpu_chip_sel_n(cst[SW-2 -: NCS]), .cpu_fetch_n(cst[4]),
    .cpu_grant_n(cst[3]), .cpu_io_req_n(cst[2]), .cpu_read_n(cst[1]), .cpu_write_n(cst[0]),
    .ext_addr(ext_addr), .ext_data(ext_data), .ext_data_oe(ext_data_oe),
    .ext_mem_req_n(ext_mem_req_n), .ext_chip_sel_n(ext_chip_sel_n), .ext_fetch_n(ext_fetch_n),
    .ext_grant_n(ext_grant_n), .ext_io_req_n(ext_io_req_n), .ext_read_n(ext_read_n),
    .ext_write_n(ext_write_n), .pc_freeze(pc_freeze), .halted(halted)
  );

  // behavioural reference state
  bit            m_halt = 1'b0;
  logic [AW-1:0] m_addr = '0;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  function automatic bit m_rst();
    return !ext_reset_n || dbg_reset || (wdt_timeout && wdt_mode == 2'd2);
  endfunction

  function automatic bit m_iw();
    return nmi_req || (irq_req && irq_gie) || (wdt_timeout && wdt_mode == 2'd1);
  endfunction

  task automatic cyc(input string tag);
    logic [2+AW+DW+1+SW-1:0] act, exp;
    bit park;
    @(negedge clk);
    ext_reset_n = s_rst_n; dbg_reset = s_dbg; halt_req = s_halt; nmi_req = s_nmi;
    irq_req = s_irq; irq_gie = s_gie; wdt_timeout = s_wdt; wdt_mode = s_mode;
    cpu_addr = AW'($urandom); cpu_data = DW'($urandom);
    cpu_data_oe = 1'($urandom); cst = SW'($urandom);
    #1;
    if (m_rst()) m_halt = 1'b0;
    park = m_halt || halt_req;
    exp = {m_halt && !m_iw(), m_halt, m_halt ? m_addr : cpu_addr,
           park ? {DW{1'b0}} : cpu_data, park ? 1'b1 : cpu_data_oe,
           park ? {SW{1'b1}} : cst};
    act = {halted, pc_freeze, ext_addr, ext_data, ext_data_oe, ext_mem_req_n,
           ext_chip_sel_n, ext_fetch_n, ext_grant_n, ext_io_req_n, ext_read_n, ext_write_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
    @(posedge clk);
    if (!m_rst()) begin
      if (m_halt) begin
        if (m_iw()) m_halt = 1'b0;
      end else if (halt_req && !m_iw()) begin
        m_halt = 1'b1;
        m_addr = cpu_addr;
      end
    end
  endtask

  task automatic go_halt();
    s_halt = 1'b1; cyc("R5");
    s_halt = 1'b0; cyc("R2");
  endtask

  initial begin
    s_halt = 1'b1;
    for (int i = 0; i < 3; i++) cyc("R1");
    s_halt = 1'b0; s_rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc("R6");

    go_halt();
    for (int i = 0; i < 4; i++) cyc("R4");
    s_irq = 1'b1; s_gie = 1'b0;
    cyc("R8"); cyc("R8");
    s_irq = 1'b0;
    s_wdt = 1'b1; s_mode = 2'b00; cyc("R9");
    s_mode = 2'b11; cyc("R9");
    s_wdt = 1'b0; s_mode = 2'b00;
    s_halt = 1'b1; cyc("R12");
    s_halt = 1'b0; cyc("R12");
    s_nmi = 1'b1; cyc("R7");
    s_nmi = 1'b0; cyc("R3"); cyc("R6");

    go_halt();
    s_irq = 1'b1; s_gie = 1'b1; cyc("R8");
    s_irq = 1'b0; s_gie = 1'b0; cyc("R8");

    go_halt();
    s_wdt = 1'b1; s_mode = 2'b01; cyc("R9");
    s_wdt = 1'b0; cyc("R9");

    go_halt();
    s_dbg = 1'b1; cyc("R10");
    s_dbg = 1'b0; cyc("R10");

    go_halt();
    s_wdt = 1'b1; s_mode = 2'b10; cyc("R10");
    s_wdt = 1'b0; s_mode = 2'b00; cyc("R9");

    go_halt();
    s_rst_n = 1'b0; cyc("R10");
    s_rst_n = 1'b1; cyc("R1");

    s_halt = 1'b1; s_nmi = 1'b1; cyc("R11");
    s_halt = 1'b0; s_nmi = 1'b0; cyc("R11");
    s_halt = 1'b1; s_irq = 1'b1; s_gie = 1'b1; cyc("R11");
    s_halt = 1'b0; s_irq = 1'b0; s_gie = 1'b0; cyc("R11");

    go_halt();
    for (int i = 0; i < 3; i++) cyc("R3");
    s_nmi = 1'b1; cyc("R3");
    s_nmi = 1'b0; cyc("R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule